// File: doc/BRIEF.md
# 8-bit to 7-bit Bus Repacker

The repacker carries an unbroken stream of 8-bit words onto a 7-bit bus. No bit is dropped and no filler bit is added. Incoming bits collect in a 14-bit staging register. In every cycle where at least seven bits are staged, the seven oldest leave on the output. The remaining bits then move down to the bottom of the register, and a newly accepted word is written directly above them.

When the stream never pauses, the schedule repeats every eight cycles. Seven words go in and eight words come out. In one of those eight cycles the staging register is full, so the input stalls while two back-to-back emissions empty it. The upstream source sees this as a one-cycle drop of its ready signal. The output has a valid flag but no back-pressure, so the downstream side must take every emitted word.

Top module: `bus_repack87`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no bits are staged: out_valid is 0 and in_ready is 1.
- R2: in_ready is 0 exactly in a cycle where 14 bits are staged. In every other cycle it is 1.
- R3: A word is taken only in a cycle where in_valid and in_ready are both 1. The number of staged bits never exceeds 14.
- R4: out_valid is 1 exactly when 7 or more bits are staged. A word is emitted in every such cycle.
- R5: The output bit stream is the accepted input bit stream in the same order. Bit 0 of each word is its earliest bit, on both the input and the output side. Each output word is made of the 7 oldest staged bits.
- R6: With in_valid held at 1 from reset, input is accepted in cycles 0 to 6, in_ready is 0 in cycle 7, and output is valid in every cycle from cycle 1 onward. This repeats with a period of 8 cycles: 7 words in and 8 words out.
- R7: When in_valid is 0, staged bits are kept and are never padded. Fewer than 7 staged bits produce no output until more input arrives.
- R8: in_data has no effect on the output stream when in_valid is 0 or in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Repacker can take a word this cycle |
| in_data | input | 8 | Input word, bit 0 earliest |
| out_valid | output | 1 | out_data carries a word this cycle |
| out_data | output | 7 | Output word, bit 0 earliest |

## Verification
Emitting seven bits and inserting a new word can happen in the same cycle. In that case the shift-down and the write must agree on the bit offset, and this is the case most likely to corrupt data. A long unbroken stream hits this collision in seven cycles out of every eight. Irregular gaps in in_valid move the insert offset to every possible fill level. A bit-level reference queue in the bench compares each emitted word, and each ready and valid flag, every cycle. Words are also offered during the full-register stall, and the check confirms they never enter the output stream.

// File: rtl/bus_repack87_pkg.sv
package bus_repack87_pkg;

   typedef enum logic {
      INS_SHIFT = 1'b0,
      INS_MUX   = 1'b1
   } ins_style_e;

   function automatic int fill_bits(input int stg_w);
      return (stg_w < 2) ? 1 : $clog2(stg_w + 1);
   endfunction

endpackage

// File: rtl/repack_ctrl.sv
module repack_ctrl
   import bus_repack87_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 7,
   parameter int STG_W = IN_W + OUT_W - 1,
   parameter int CNT_W = fill_bits(STG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             out_valid,
   output logic             accept,
   output logic [CNT_W-1:0] rem,
   output logic [CNT_W-1:0] fill
);

   localparam logic [CNT_W-1:0] OUT_STEP  = CNT_W'(OUT_W);
   localparam logic [CNT_W-1:0] IN_STEP   = CNT_W'(IN_W);
   localparam logic [CNT_W-1:0] ROOM_LIM  = CNT_W'(STG_W - IN_W);
   localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(STG_W);

   logic [CNT_W-1:0] fill_q;
   logic [CNT_W-1:0] fill_d;

   always_comb begin
      out_valid = (fill_q >= OUT_STEP);
      rem       = out_valid ? (fill_q - OUT_STEP) : fill_q;
      in_ready  = (rem <= ROOM_LIM);
      accept    = in_valid && in_ready;
      fill_d    = accept ? (rem + IN_STEP) : rem;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_q <= '0;
      else        fill_q <= fill_d;
   end

   assign fill = fill_q;

   // R3: staging never holds more bits than it has positions
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL_LVL);

   // R2: a full register refuses input
   a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FULL_LVL) |-> !in_ready);

   // R6: the cycle after the drain-only cycle still emits
   a_r6_drain_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FULL_LVL) |=> out_valid);

   // R7: without input and without enough bits, the level holds
   a_r7_hold_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !out_valid) |=> $stable(fill_q));

endmodule

// File: rtl/repack_stage.sv
module repack_stage
   import bus_repack87_pkg::*;
#(
   parameter int         IN_W  = 8,
   parameter int         OUT_W = 7,
   parameter int         STG_W = IN_W + OUT_W - 1,
   parameter int         CNT_W = fill_bits(STG_W),
   parameter ins_style_e STYLE = INS_MUX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic             accept,
   input  logic [CNT_W-1:0] rem,
   input  logic [IN_W-1:0]  in_data,
   output logic [STG_W-1:0] stage
);

   logic [STG_W-1:0] stg_q;
   logic [STG_W-1:0] kept;
   logic [STG_W-1:0] stg_d;

   assign kept = pop ? (stg_q >> OUT_W) : stg_q;

   generate
      if (STYLE == INS_SHIFT) begin : g_shift
         logic [STG_W-1:0] wide_in;
         assign wide_in = STG_W'(in_data) << rem;
         assign stg_d   = accept ? (kept | wide_in) : kept;
      end else begin : g_mux
         for (genvar i = 0; i < STG_W; i++) begin : g_bit
            logic       hit;
            logic [IN_W-1:0] sel;
            always_comb begin
               hit = 1'b0;
               sel = '0;
               for (int k = 0; k < IN_W; k++) begin
                  if (32'(rem) + k == i) begin
                     hit    = 1'b1;
                     sel[k] = 1'b1;
                  end
               end
            end
            assign stg_d[i] = (accept && hit) ? |(sel & in_data) : kept[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
   end

   assign stage = stg_q;

   // R5: a pop moves the bits above the emitted ones down to the bottom
   a_r5_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !accept) |=> (stg_q == ($past(stg_q) >> OUT_W)));

endmodule

// File: rtl/bus_repack87.sv
module bus_repack87
   import bus_repack87_pkg::*;
#(
   parameter int         IN_W  = 8,
   parameter int         OUT_W = 7,
   parameter ins_style_e STYLE = INS_MUX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   localparam int STG_W = IN_W + OUT_W - 1;
   localparam int CNT_W = fill_bits(STG_W);

   initial begin
      assert (OUT_W >= 1) else $error("OUT_W must be at least 1");
      assert (IN_W > OUT_W) else $error("IN_W must exceed OUT_W");
      assert (IN_W <= 2 * OUT_W) else $error("IN_W too wide for staging");
   end

   logic             accept;
   logic [CNT_W-1:0] rem;
   logic [CNT_W-1:0] fill;
   logic [STG_W-1:0] stage;

   repack_ctrl #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .STG_W(STG_W),
      .CNT_W(CNT_W)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .accept   (accept),
      .rem      (rem),
      .fill     (fill)
   );

   repack_stage #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .STG_W(STG_W),
      .CNT_W(CNT_W),
      .STYLE(STYLE)
   ) stage_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pop    (out_valid),
      .accept (accept),
      .rem    (rem),
      .in_data(in_data),
      .stage  (stage)
   );

   assign out_data = stage[OUT_W-1:0];

   // R7: positions above the fill level stay clear, so no padding appears
   a_r7_no_padding: assert property (@(posedge clk) disable iff (!rst_n)
      (stage >> fill) == '0);

   // R3: an accepted word is reflected in the next fill level
   a_r3_word_counted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (fill >= CNT_W'(IN_W)));

   // R4: emitting a word means a word's worth of bits was staged
   a_r4_valid_level: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (fill >= CNT_W'(OUT_W)));

endmodule

// File: tb/bus_repack87_tb_top.sv
module bus_repack87_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic       in_ready;
   logic [7:0] in_data;
   logic       out_valid;
   logic [6:0] out_data;

   int n_chk  = 0;
   int n_fail = 0;

   logic [63:0] mdl;
   int          mcnt;

   always #5 clk = ~clk;

   bus_repack87 dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   localparam int NVEC = 32;
   localparam logic [8:0] VEC [NVEC] = '{
      9'h1A5, 9'h13C, 9'h1FF, 9'h100, 9'h181, 9'h17E, 9'h1C3, 9'h15A,
      9'h0AA, 9'h0FF, 9'h112, 9'h034, 9'h156, 9'h078, 9'h19A, 9'h1BC,
      9'h1DE, 9'h1F0, 9'h1E1, 9'h1D2, 9'h0C3, 9'h0B4, 9'h0A5, 9'h196,
      9'h187, 9'h000, 9'h169, 9'h15A, 9'h14B, 9'h13C, 9'h12D, 9'h11E
   };

   task automatic model_reset();
      mdl  = '0;
      mcnt = 0;
   endtask

   task automatic step(input logic v, input logic [7:0] d, input string tag);
      logic       e_valid;
      logic [6:0] e_data;
      logic       e_ready;
      int         left;
      @(negedge clk);
      in_valid = v;
      in_data  = d;
      #1;
      e_valid = (mcnt >= 7);
      e_data  = mdl[6:0];
      left    = e_valid ? mcnt - 7 : mcnt;
      e_ready = (left + 8 <= 14);
      n_chk++;
      if (out_valid !== e_valid || in_ready !== e_ready ||
          (e_valid && out_data !== e_data)) begin
         n_fail++;
         $display("FAIL %s: valid=%0b ready=%0b data=%h expected valid=%0b ready=%0b data=%h",
                  tag, out_valid, in_ready, out_data, e_valid, e_ready, e_data);
      end
      if (e_valid) mdl = mdl >> 7;
      mcnt = left;
      if (v && e_ready) begin
         mdl  = mdl | (64'(d) << mcnt);
         mcnt = mcnt + 8;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      #1;
      n_chk++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_fail++;
         $display("FAIL R1: valid=%0b ready=%0b expected valid=0 ready=1",
                  out_valid, in_ready);
      end
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R6: watchdog expired, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int acc_cnt;
      int out_cnt;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      model_reset();
      repeat (2) @(negedge clk);
      do_reset();

      // R1: first cycle after reset
      step(1'b0, 8'hEE, "R1 idle after reset");

      // R4 R5 R3: vector table, mixed gaps
      for (int i = 0; i < NVEC; i++)
         step(VEC[i][8], VEC[i][7:0], "R5 table");
      for (int i = 0; i < 4; i++)
         step(1'b0, 8'h5C, "R7 drain");

      // R6: continuous stream schedule from a fresh reset
      do_reset();
      acc_cnt = 0;
      out_cnt = 0;
      for (int c = 0; c < 16; c++) begin
         step(1'b1, 8'(c * 37 + 11), "R2 R6 stream");
         if (in_ready) acc_cnt++;
         if (out_valid) out_cnt++;
         n_chk++;
         if (in_ready !== ((c % 8) != 7)) begin
            n_fail++;
            $display("FAIL R6: cycle %0d ready=%0b expected=%0b", c, in_ready, (c % 8) != 7);
         end
      end
      n_chk++;
      if (acc_cnt != 14 || out_cnt != 15) begin
         n_fail++;
         $display("FAIL R6: accepts=%0d outputs=%0d expected 14 and 15", acc_cnt, out_cnt);
      end

      // R7: leave a partial word, wait, then complete it
      do_reset();
      step(1'b1, 8'hC9, "R7 load");
      step(1'b0, 8'hFF, "R7 emit");
      for (int i = 0; i < 5; i++)
         step(1'b0, 8'hFF, "R7 hold one bit");
      step(1'b1, 8'h36, "R7 resume");
      step(1'b0, 8'h00, "R7 emit");
      step(1'b0, 8'h00, "R7 emit rest");

      // R8: data ignored while in_valid low and while stalled
      do_reset();
      for (int c = 0; c < 10; c++)
         step(1'b1, (c == 7) ? 8'hFF : 8'h00, "R8 stall ignore");
      for (int i = 0; i < 4; i++)
         step(1'b0, 8'hFF, "R8 invalid ignore");

      // R1: reset in the middle of a stream
      for (int i = 0; i < 3; i++)
         step(1'b1, 8'h81, "R1 pre");
      do_reset();
      step(1'b0, 8'h00, "R1 after mid reset");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule